// File: doc/BRIEF.md
# Double-Buffered Timer Period and Compare Register Bank

This block holds the active period value and a set of compare values of a timer, together with a shadow buffer for each. Software writes normally land in a shadow buffer and raise that buffer's pending flag. The active value is left alone. When the timer core raises a one-cycle update pulse, each shadow whose pending flag is set moves into its active register, and that flag is cleared. Shadows with no pending flag leave their active register untouched.

Every active register also has its own direct-write address. A write there reaches the active register at once, skips the shadow, and leaves the pending flag as it was. The active values and the pending flags are outputs, so the timer core and a status read path can use them.

Top module: `tmr_dbuf_bank`

## Requirements
- R1: After a synchronous reset, the active period is all ones (0xFFFF), every active compare is zero, and every pending flag is clear.
- R2: A write to a shadow address (0 = period, 1..4 = compare 0..3) stores the data in that shadow and sets its pending flag on the next clock. The active registers do not change.
- R3: On an update pulse, every shadow whose pending flag is set is copied into its active register on the next clock, and that flag is cleared.
- R4: On an update pulse, an active register whose pending flag is clear keeps its value.
- R5: When a shadow write and an update land in the same cycle, the earlier shadow value is transferred. The new data stays in the shadow with its flag set, and a later update transfers it.
- R6: A write to a direct address (8 = period, 9..12 = compare 0..3) loads the active register on the next clock. It changes neither the shadow nor the pending flag.
- R7: Pending flags are reported on the status output with bit 0 = period and bit 1+k = compare k. The flags stay set until an update clears them.
- R8: A write to an unmapped address changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| upd | input | 1 | Update pulse |
| period_o | output | 16 | Active period |
| cmp_o | output | 64 | Active compares, compare k in bits 16k+15:16k |
| pend_o | output | 5 | Pending flags, bit 0 = period, bit 1+k = compare k |

## Verification
Each write, update, direct load and reset acts on the first rising edge after the cycle in which it is presented, so its result shows at the ports one clock later. The bench drives inputs on the falling edge and samples outputs on the next falling edge, half a cycle after the edge that registers them. For the collision case (R5), the bench samples the active value one cycle after the combined write and update. It then issues a second update and checks that the new data arrives one cycle after that.

// File: rtl/tmr_dbuf_pkg.sv
package tmr_dbuf_pkg;
    localparam int unsigned DW      = 16;
    localparam int unsigned NCMP    = 4;
    localparam int unsigned NREG    = NCMP + 1;
    localparam int unsigned AW      = 4;
    localparam logic [AW-1:0] DIRECT_BASE = 4'd8;

    typedef enum logic [1:0] {ACC_NONE, ACC_SHADOW, ACC_DIRECT} acc_e;

    typedef struct packed {
        acc_e            kind;
        logic [AW-1:0]   idx;
    } dec_t;

    function automatic dec_t decode(input logic en, input logic [AW-1:0] a);
        dec_t d;
        d.kind = ACC_NONE;
        d.idx  = '0;
        if (en) begin
            if (a < AW'(NREG)) begin
                d.kind = ACC_SHADOW;
                d.idx  = a;
            end else if (a >= DIRECT_BASE && a < DIRECT_BASE + AW'(NREG)) begin
                d.kind = ACC_DIRECT;
                d.idx  = a - DIRECT_BASE;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/tmr_dbuf_slot.sv
module tmr_dbuf_slot #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sh_we,
    input  logic         dir_we,
    input  logic [W-1:0] din,
    input  logic         upd,
    output logic [W-1:0] act_q,
    output logic         pend_q
);
    logic [W-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= RST_VAL;
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (sh_we) shadow_q <= din;
            if (upd && pend_q) act_q <= shadow_q;
            else if (dir_we)   act_q <= din;
            if (sh_we)         pend_q <= 1'b1;
            else if (upd)      pend_q <= 1'b0;
        end
    end

    assert_upd_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (upd && !sh_we) |=> !pend_q);
    assert_write_sets_R2: assert property (@(posedge clk) disable iff (rst)
        sh_we |=> pend_q);
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (upd && !pend_q && !dir_we) |=> $stable(act_q));
    assert_direct_keeps_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (dir_we && !sh_we && !upd) |=> $stable(pend_q));
endmodule

// File: rtl/tmr_dbuf_bank.sv
module tmr_dbuf_bank
    import tmr_dbuf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic                 upd,
    output logic [DW-1:0]        period_o,
    output logic [NCMP*DW-1:0]   cmp_o,
    output logic [NREG-1:0]      pend_o
);
    dec_t dec;
    logic [NREG-1:0] sh_we, dir_we;
    logic [DW-1:0]   act [NREG];

    always_comb begin
        dec    = decode(wr_en, wr_addr);
        sh_we  = '0;
        dir_we = '0;
        for (int i = 0; i < NREG; i++) begin
            sh_we[i]  = (dec.kind == ACC_SHADOW) && (dec.idx == AW'(i));
            dir_we[i] = (dec.kind == ACC_DIRECT) && (dec.idx == AW'(i));
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam logic [DW-1:0] RV = (g == 0) ? {DW{1'b1}} : '0;
        tmr_dbuf_slot #(.W(DW), .RST_VAL(RV)) u_slot (
            .clk(clk), .rst(rst), .sh_we(sh_we[g]), .dir_we(dir_we[g]),
            .din(wr_data), .upd(upd), .act_q(act[g]), .pend_q(pend_o[g])
        );
        if (g > 0) begin : g_cmp
            assign cmp_o[(g-1)*DW +: DW] = act[g];
        end
    end
    assign period_o = act[0];

    assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sh_we, dir_we}));
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (pend_o == '0 && period_o == '1 && cmp_o == '0));
    assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !upd) |=> ($stable(pend_o) && $stable(period_o) && $stable(cmp_o)));
endmodule

// File: tb/tb_tmr_dbuf_bank.sv
module tb_tmr_dbuf_bank;
    logic clk = 0, rst = 1, wr_en = 0, upd = 0;
    logic [3:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] period_o;
    logic [63:0] cmp_o;
    logic [4:0]  pend_o;
    int n_chk = 0, n_bad = 0;

    tmr_dbuf_bank dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic u);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d; upd = u;
        @(negedge clk);
        wr_en = 0; upd = 0;
    endtask

    task automatic pulse();
        @(negedge clk); upd = 1;
        @(negedge clk); upd = 0;
    endtask

    function automatic logic [15:0] cmp(input int k);
        return cmp_o[k*16 +: 16];
    endfunction

    task automatic t_reset();
        chk("R1 period", period_o, 16'hFFFF);
        chk("R1 cmp", cmp_o, 64'h0);
        chk("R1 pend", pend_o, 5'h0);
    endtask

    task automatic t_shadow();
        wr(4'd0, 16'h1234, 0);
        wr(4'd3, 16'hBEEF, 0);
        chk("R2 pend", pend_o, 5'b01001);
        chk("R2 period held", period_o, 16'hFFFF);
        chk("R2 cmp2 held", cmp(2), 16'h0);
        pulse(); pulse();
        chk("R7 pend stays till upd", pend_o, 5'b0);
        chk("R3 period", period_o, 16'h1234);
        chk("R3 cmp2", cmp(2), 16'hBEEF);
        chk("R4 cmp0 kept", cmp(0), 16'h0);
    endtask

    task automatic t_idle_upd();
        wr(4'd2, 16'h0042, 0);
        chk("R7 bit2", pend_o, 5'b00100);
        pulse();
        chk("R3 cmp1", cmp(1), 16'h0042);
        chk("R4 period kept", period_o, 16'h1234);
        chk("R4 cmp2 kept", cmp(2), 16'hBEEF);
    endtask

    task automatic t_collide();
        wr(4'd4, 16'h1111, 0);
        wr(4'd4, 16'h2222, 1);
        chk("R5 old moved", cmp(3), 16'h1111);
        chk("R5 flag kept", pend_o, 5'b10000);
        pulse();
        chk("R5 new moved", cmp(3), 16'h2222);
        chk("R5 flag clear", pend_o, 5'b0);
    endtask

    task automatic t_direct();
        wr(4'd1, 16'hAAAA, 0);
        wr(4'd9, 16'h5555, 0);
        chk("R6 direct cmp0", cmp(0), 16'h5555);
        chk("R6 flag kept", pend_o, 5'b00010);
        wr(4'd8, 16'h7777, 0);
        chk("R6 direct period", period_o, 16'h7777);
        pulse();
        chk("R6 shadow intact", cmp(0), 16'hAAAA);
    endtask

    task automatic t_unmapped();
        wr(4'd5, 16'hDEAD, 0);
        wr(4'd15, 16'hDEAD, 0);
        wr(4'd7, 16'hDEAD, 0);
        chk("R8 pend", pend_o, 5'b0);
        chk("R8 period", period_o, 16'h7777);
        chk("R8 cmp", cmp_o, {16'h2222, 16'hBEEF, 16'h0042, 16'hAAAA});
        pulse();
        chk("R8 no stray transfer", cmp_o, {16'h2222, 16'hBEEF, 16'h0042, 16'hAAAA});
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 0;
                @(negedge clk);
                t_reset();
                t_shadow();
                t_idle_upd();
                t_collide();
                t_direct();
                t_unmapped();
            end
            begin
                repeat (5000) @(negedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule